// File: doc/BRIEF.md
# Embedded Timer Unit with Watchdog

This block gathers the three timers that an embedded core keeps next to its time base. A down-counting interval timer counts on a tick strobe from an external time-base counter. It can reload itself after each expiry. A fixed interval timer fires on each rising edge of one of four bits of the time-base value. A watchdog watches another set of four time-base bits and escalates through two status bits before it issues one of three reset requests. A control register sets how the timers behave, and a status register records their events. Software clears status bits by writing ones to them.

The time-base counter and the bus fabric are outside the block. The time-base value, its tick strobe and three write strobes with a shared data word come in as plain ports. Both registers and the interval count are brought out for reads.

Top module: `emb_timer_unit`

## Requirements
- R1: After reset, the control and status registers, the interval count, all interrupts and all reset requests are zero. A control write keeps only data bits 31:22. Every other control bit reads as zero.
- R2: A status write clears each status bit in 31:26 that is written as one and leaves the other status bits unchanged. A timer event in the same cycle wins over the clear.
- R3: When the interval reload value is 0 or 1, the interval timer does not count and never expires, even if control bit 26 is set.
- R4: A reload write of N (N > 1), with control bit 26 set, makes the timer expire on the N-th tick. At that point status bit 27 sets and the interval interrupt rises. The interval interrupt is never high unless status bit 27 and control bit 26 are both set.
- R5: When control bit 22 (auto-reload) is set, the count returns to the reload value at expiry and counting continues. When bit 22 is clear, the count goes to 0 and the timer stays stopped until the next reload write.
- R6: Control bits 25:24 = s select time-base bit 9+4*s as the fixed-interval tap. A 0-to-1 change of that bit sets status bit 26. Edges on the other taps have no effect.
- R7: The fixed-interval interrupt equals status bit 26 AND control bit 23.
- R8: Control bits 31:30 = s select time-base bit 17+4*s as the watchdog tap. A rising edge of the tap while status bit 31 is clear sets status bit 31.
- R9: A watchdog edge with status bits 31:30 = 10 sets bit 30. The watchdog interrupt equals status bit 30 AND control bit 27.
- R10: A watchdog edge with status bits 31:30 = 11 copies control bits 29:28 into status bits 29:28. It also gives a one-cycle pulse on the core (code 1), chip (code 2) or system (code 3) reset request. Code 0 gives no pulse. At most one request is high at a time.
- R11: A status write with bit 31 set drops the interval interrupt, even though status bit 27 stays set.
- R12: Clearing control bit 26 freezes the interval count. Setting it again resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_value | input | TB_W | Current time-base value |
| tb_tick | input | 1 | One-cycle time-base tick strobe |
| ctrl_we | input | 1 | Control register write strobe |
| tsr_we | input | 1 | Status register write-one-to-clear strobe |
| pit_we | input | 1 | Interval reload write strobe |
| wr_data | input | 32 | Write data shared by the three strobes |
| ctrl_q | output | 32 | Control register contents |
| stat_q | output | 32 | Status register contents |
| pit_count | output | PIT_W | Current interval count |
| pit_irq | output | 1 | Interval timer interrupt (level) |
| fit_irq | output | 1 | Fixed interval interrupt (level) |
| wdt_irq | output | 1 | Watchdog interrupt (level) |
| rst_core_req | output | 1 | Core reset request pulse |
| rst_chip_req | output | 1 | Chip reset request pulse |
| rst_sys_req | output | 1 | System reset request pulse |

## Verification
Every register write, tick and tap edge takes effect at the first clock edge that samples it. So status bits, the count, both registers and the level interrupts can be read one edge later. The reset requests are registered at that same edge and drop again one edge after that. The bench drives its inputs and samples the outputs 1 ns after each rising edge, once that edge has been taken. It checks each reset pulse in the cycle it appears and again in the cycle after.

// File: rtl/etu_pkg.sv
// Package for the embedded timer unit.
// Holds the register bit positions and the write masks, plus the encoding of
// the watchdog reset action. The bit positions are fixed by software, so they
// are not parameters.
package etu_pkg;
    localparam int REG_W        = 32;
    localparam logic [REG_W-1:0] CTRL_KEEP = 32'hFFC0_0000;
    localparam logic [REG_W-1:0] STAT_W1C  = 32'hFC00_0000;

    // control bit positions
    localparam int C_WD_SEL_HI  = 31;
    localparam int C_WD_SEL_LO  = 30;
    localparam int C_WD_ACT_HI  = 29;
    localparam int C_WD_ACT_LO  = 28;
    localparam int C_WD_IE      = 27;
    localparam int C_PIT_IE     = 26;
    localparam int C_FIT_SEL_HI = 25;
    localparam int C_FIT_SEL_LO = 24;
    localparam int C_FIT_IE     = 23;
    localparam int C_PIT_ARL    = 22;

    // status bit positions
    localparam int S_WD_ARM     = 31;
    localparam int S_WD_INT     = 30;
    localparam int S_WD_ACT_HI  = 29;
    localparam int S_WD_ACT_LO  = 28;
    localparam int S_PIT        = 27;
    localparam int S_FIT        = 26;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CORE = 2'd1,
        ACT_CHIP = 2'd2,
        ACT_SYS  = 2'd3
    } wd_action_e;
endpackage

// File: rtl/etu_tap_edge.sv
// Tap selector with a rising-edge detector.
// Picks time-base bit BASE + STEP*sel and flags a 0-to-1 change of the chosen
// bit against its value in the previous cycle.
// Assumes: BASE + STEP*(NSEL-1) < TB_W. A change of sel may itself look like
// an edge when the newly selected bit is already high.
module etu_tap_edge #(
    parameter int TB_W  = 32,
    parameter int BASE  = 9,
    parameter int STEP  = 4,
    parameter int NSEL  = 4,
    localparam int SW   = $clog2(NSEL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb,
    input  logic [SW-1:0]   sel,
    output logic            rise
);
    logic [NSEL-1:0] taps;
    logic            cur;
    logic            prev_q;

    for (genvar i = 0; i < NSEL; i++) begin : g_tap
        assign taps[i] = tb[BASE + STEP*i];
    end

    assign cur  = taps[sel];
    assign rise = cur & ~prev_q;

    // remember the selected tap for the next cycle's comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end
endmodule

// File: rtl/etu_pit.sv
// Programmable interval down-counter.
// A load sets the reload value and the count, and arms the timer. The timer
// counts on tick while it is armed, enabled, and its reload value is above 1.
// It expires on a tick seen at a count of 1 or less. With auto-reload the count
// returns to the reload value; without it the count goes to 0 and the timer
// disarms. A load in the same cycle as a tick takes priority.
module etu_pit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         enable,
    input  logic         auto_rl,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] reload_q;
    logic [W-1:0] cnt_q;
    logic         armed_q;
    logic         running;

    assign running = armed_q && (reload_q > W'(1)) && enable;
    assign expire  = running && tick && !load && (cnt_q <= W'(1));
    assign count   = cnt_q;

    // reload register, count and armed flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            armed_q  <= 1'b0;
        end else if (load) begin
            reload_q <= load_val;
            cnt_q    <= load_val;
            armed_q  <= 1'b1;
        end else if (running && tick) begin
            if (cnt_q <= W'(1)) begin
                cnt_q   <= auto_rl ? reload_q : '0;
                armed_q <= auto_rl;
            end else begin
                cnt_q   <= cnt_q - W'(1);
            end
        end
    end
endmodule

// File: rtl/etu_wdog.sv
// Watchdog escalation step.
// Decodes one tap expiry against the two state bits of the status register
// into one of three actions: arm, interrupt, or apply the reset action. Each
// reset request is a registered one-cycle pulse.
// Assumes: state is status bits 31:30, and action is control bits 29:28.
module etu_wdog (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic [1:0] state,
    input  logic [1:0] action,
    output logic       set_arm,
    output logic       set_int,
    output logic       do_act,
    output logic [3:1] rst_req
);
    // decode the escalation step for this expiry
    always_comb begin
        set_arm = expire && !state[1];
        set_int = expire && (state == 2'b10);
        do_act  = expire && (state == 2'b11);
    end

    for (genvar k = 1; k <= 3; k++) begin : g_req
        // one-cycle pulse when the applied action code equals k
        always_ff @(posedge clk) begin
            if (!rst_n) rst_req[k] <= 1'b0;
            else        rst_req[k] <= do_act && (action == 2'(k));
        end
    end
endmodule

// File: rtl/emb_timer_unit.sv
// Embedded timer unit (top).
// Holds the control and status registers and the pending flag of the interval
// interrupt, and wires up the interval counter, the two tap detectors and the
// watchdog step. Writes take effect at the sampling edge. Timer events win
// over status clears made in the same cycle.
// Assumes: tb_value comes from a free-running time base, and tb_tick pulses
// for one cycle per time-base count.
module emb_timer_unit #(
    parameter int TB_W     = 32,
    parameter int PIT_W    = 32,
    parameter int FIT_BASE = 9,
    parameter int WDT_BASE = 17,
    parameter int TAP_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TB_W-1:0]  tb_value,
    input  logic             tb_tick,
    input  logic             ctrl_we,
    input  logic             tsr_we,
    input  logic             pit_we,
    input  logic [31:0]      wr_data,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      stat_q,
    output logic [PIT_W-1:0] pit_count,
    output logic             pit_irq,
    output logic             fit_irq,
    output logic             wdt_irq,
    output logic             rst_core_req,
    output logic             rst_chip_req,
    output logic             rst_sys_req
);
    import etu_pkg::*;

    logic [31:0] ctrl_r, stat_r, stat_nx;
    logic        pit_pend_q;
    logic        pit_exp, fit_exp, wdt_exp;
    logic        wd_arm, wd_int, wd_act;
    logic [3:1]  rst_vec;

    etu_pit #(.W(PIT_W)) u_pit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pit_we),
        .load_val (wr_data[PIT_W-1:0]),
        .tick     (tb_tick),
        .enable   (ctrl_r[C_PIT_IE]),
        .auto_rl  (ctrl_r[C_PIT_ARL]),
        .count    (pit_count),
        .expire   (pit_exp)
    );

    etu_tap_edge #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(TAP_STEP), .NSEL(4)) u_fit (
        .clk   (clk),
        .rst_n (rst_n),
        .tb    (tb_value),
        .sel   (ctrl_r[C_FIT_SEL_HI:C_FIT_SEL_LO]),
        .rise  (fit_exp)
    );

    etu_tap_edge #(.TB_W(TB_W), .BASE(WDT_BASE), .STEP(TAP_STEP), .NSEL(4)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .tb    (tb_value),
        .sel   (ctrl_r[C_WD_SEL_HI:C_WD_SEL_LO]),
        .rise  (wdt_exp)
    );

    etu_wdog u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (wdt_exp),
        .state   (stat_r[S_WD_ARM:S_WD_INT]),
        .action  (ctrl_r[C_WD_ACT_HI:C_WD_ACT_LO]),
        .set_arm (wd_arm),
        .set_int (wd_int),
        .do_act  (wd_act),
        .rst_req (rst_vec)
    );

    // next status: write-one-to-clear first, then event sets override
    always_comb begin
        stat_nx = stat_r;
        if (tsr_we) stat_nx = stat_r & ~(wr_data & STAT_W1C);
        if (pit_exp) stat_nx[S_PIT]    = 1'b1;
        if (fit_exp) stat_nx[S_FIT]    = 1'b1;
        if (wd_arm)  stat_nx[S_WD_ARM] = 1'b1;
        if (wd_int)  stat_nx[S_WD_INT] = 1'b1;
        if (wd_act)  stat_nx[S_WD_ACT_HI:S_WD_ACT_LO] = ctrl_r[C_WD_ACT_HI:C_WD_ACT_LO];
    end

    // control register, status register and interval-interrupt pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_r     <= '0;
            stat_r     <= '0;
            pit_pend_q <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_r <= wr_data & CTRL_KEEP;
            stat_r     <= stat_nx;
            pit_pend_q <= pit_exp ||
                          (pit_pend_q && !(tsr_we && (wr_data[S_PIT] || wr_data[S_WD_ARM])));
        end
    end

    assign ctrl_q       = ctrl_r;
    assign stat_q       = stat_r;
    assign pit_irq      = pit_pend_q & ctrl_r[C_PIT_IE];
    assign fit_irq      = stat_r[S_FIT] & ctrl_r[C_FIT_IE];
    assign wdt_irq      = stat_r[S_WD_INT] & ctrl_r[C_WD_IE];
    assign rst_core_req = rst_vec[ACT_CORE];
    assign rst_chip_req = rst_vec[ACT_CHIP];
    assign rst_sys_req  = rst_vec[ACT_SYS];
endmodule

// File: rtl/etu_sva.sv
// Property checker for the embedded timer unit. It is attached to every
// instance of the top by the bind statement at the end of this file.
module etu_sva #(
    parameter int PIT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic             pit_we,
    input logic [31:0]      wr_data,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      stat_q,
    input logic [PIT_W-1:0] pit_count,
    input logic             pit_irq,
    input logic             wdt_irq,
    input logic             rst_core_req,
    input logic             rst_chip_req,
    input logic             rst_sys_req
);
    // R1
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_q == ($past(wr_data) & 32'hFFC0_0000));
    // R4
    pit_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pit_irq |-> (stat_q[27] && ctrl_q[26]));
    // R9
    wdt_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |-> (stat_q[30] && ctrl_q[27]));
    // R10
    rst_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_core_req, rst_chip_req, rst_sys_req}));
    // R10
    rst_core_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_core_req |-> stat_q[29:28] == 2'd1);
    // R10
    rst_chip_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_chip_req |-> stat_q[29:28] == 2'd2);
    // R10
    rst_sys_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sys_req |-> stat_q[29:28] == 2'd3);
    // R12
    pit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[26] && !pit_we) |=> $stable(pit_count));
endmodule

bind emb_timer_unit etu_sva #(.PIT_W(PIT_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .pit_we       (pit_we),
    .wr_data      (wr_data),
    .ctrl_q       (ctrl_q),
    .stat_q       (stat_q),
    .pit_count    (pit_count),
    .pit_irq      (pit_irq),
    .wdt_irq      (wdt_irq),
    .rst_core_req (rst_core_req),
    .rst_chip_req (rst_chip_req),
    .rst_sys_req  (rst_sys_req)
);

// File: tb/tb_emb_timer_unit.sv
// Bench for emb_timer_unit. It mixes seeded random register data with directed
// timer sequences. Inputs change and outputs are sampled 1 ns after each
// rising clock edge.
module tb_emb_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tb_value = '0;
    logic        tb_tick = 1'b0;
    logic        ctrl_we = 1'b0, tsr_we = 1'b0, pit_we = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_q, stat_q, pit_count;
    logic        pit_irq, fit_irq, wdt_irq, rst_core_req, rst_chip_req, rst_sys_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    emb_timer_unit dut (
        .clk(clk), .rst_n(rst_n), .tb_value(tb_value), .tb_tick(tb_tick),
        .ctrl_we(ctrl_we), .tsr_we(tsr_we), .pit_we(pit_we), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .pit_count(pit_count),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
        .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req), .rst_sys_req(rst_sys_req)
    );

    function automatic int fit_bit(input int s); return 9 + 4*s;  endfunction
    function automatic int wdt_bit(input int s); return 17 + 4*s; endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_we = 1; wr_data = v; cyc(); ctrl_we = 0;
    endtask
    task automatic wr_tsr(input logic [31:0] v);
        tsr_we = 1; wr_data = v; cyc(); tsr_we = 0;
    endtask
    task automatic wr_pit(input logic [31:0] v);
        pit_we = 1; wr_data = v; cyc(); pit_we = 0;
    endtask
    task automatic tick(); tb_tick = 1; cyc(); tb_tick = 0; endtask
    task automatic pulse_bit(input int b);
        tb_value = 32'd1 << b; cyc(); tb_value = '0; cyc();
    endtask

    // bring status bits 31, 30, 27 and 26 up together
    task automatic fill_status();
        wr_tsr(32'hFFFF_FFFF);
        wr_ctrl(32'h0440_0000);       // interval enable + auto-reload, taps 9 and 17
        wr_pit(32'd2); tick(); tick();
        pulse_bit(9);
        pulse_bit(17); pulse_bit(17);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          s;
        process::self().srandom(32'd1234);
        repeat (3) cyc();
        rst_n = 1; cyc();
        // R1 reset state
        check("R1 ctrl reset", ctrl_q, 0);
        check("R1 stat reset", stat_q, 0);
        check("R1 count reset", pit_count, 0);
        check("R1 outputs reset", {26'd0, pit_irq, fit_irq, wdt_irq, rst_core_req, rst_chip_req, rst_sys_req}, 0);

        // R1 random control data keeps only 31:22
        for (int i = 0; i < 8; i++) begin
            v = $urandom;
            wr_ctrl(v);
            check("R1 ctrl mask", ctrl_q, v & 32'hFFC0_0000);
        end
        wr_ctrl(0);

        // R2 random write-one-to-clear
        for (int i = 0; i < 6; i++) begin
            fill_status();
            check("R2 filled", stat_q, 32'hCC00_0000);
            v = $urandom;
            wr_tsr(v);
            check("R2 w1c", stat_q, 32'hCC00_0000 & ~(v & 32'hFC00_0000));
        end

        // R11 status bit 31 write drops the interval interrupt, bit 27 stays
        fill_status();
        check("R11 irq before", {31'd0, pit_irq}, 1);
        wr_tsr(32'h8000_0000);
        check("R11 irq dropped", {31'd0, pit_irq}, 0);
        check("R11 stat27 kept", {31'd0, stat_q[27]}, 1);
        wr_tsr(32'hFFFF_FFFF);

        // R3 reload 1 and 0 never count
        wr_ctrl(32'h0440_0000);
        wr_pit(32'd1); tick(); tick(); tick();
        check("R3 reload1 count", pit_count, 1);
        check("R3 reload1 no expiry", {31'd0, stat_q[27]}, 0);
        wr_pit(32'd0); tick(); tick();
        check("R3 reload0 no expiry", {31'd0, stat_q[27]}, 0);

        // R4 / R5 auto-reload: expiry on the N-th tick
        wr_pit(32'd5);
        repeat (4) tick();
        check("R4 count before expiry", pit_count, 1);
        check("R4 no early expiry", {31'd0, stat_q[27]}, 0);
        tick();
        check("R4 expiry stat", {31'd0, stat_q[27]}, 1);
        check("R4 expiry irq", {31'd0, pit_irq}, 1);
        check("R5 reloaded", pit_count, 5);
        tick();
        check("R5 keeps counting", pit_count, 4);
        wr_tsr(32'h0800_0000);
        check("R4 irq cleared", {31'd0, pit_irq}, 0);

        // R5 one-shot
        wr_ctrl(32'h0400_0000);
        wr_pit(32'd3); repeat (3) tick();
        check("R5 oneshot expiry", {31'd0, stat_q[27]}, 1);
        check("R5 oneshot count", pit_count, 0);
        wr_tsr(32'h0800_0000);
        repeat (4) tick();
        check("R5 stays stopped", {31'd0, stat_q[27]}, 0);
        check("R5 stopped count", pit_count, 0);

        // R12 disable freezes, enable resumes
        wr_pit(32'd6); tick(); tick();
        check("R12 counting", pit_count, 4);
        wr_ctrl(32'h0000_0000);
        repeat (3) tick();
        check("R12 frozen", pit_count, 4);
        wr_ctrl(32'h0400_0000);
        tick();
        check("R12 resumed", pit_count, 3);
        wr_pit(32'd0);
        wr_tsr(32'hFFFF_FFFF);

        // R6 / R7 fixed interval taps (watchdog on bit 29, never driven here)
        for (int i = 0; i < 4; i++) begin
            s = i;
            wr_ctrl(32'hC000_0000 | (32'(s) << 24) | (32'(i % 2) << 23));
            pulse_bit(fit_bit((s + 1) % 4));
            check("R6 other tap ignored", {31'd0, stat_q[26]}, 0);
            tb_value = 32'd1 << fit_bit(s); cyc();
            check("R6 tap edge", {31'd0, stat_q[26]}, 1);
            check("R7 fit irq", {31'd0, fit_irq}, 32'(i % 2));
            tb_value = '0; cyc();
            wr_tsr(32'h0400_0000);
            check("R7 fit cleared", {31'd0, fit_irq}, 0);
        end

        // R8 / R9 / R10 watchdog escalation for each action code
        for (int code = 0; code < 4; code++) begin
            s = int'($urandom % 4);
            wr_ctrl((32'(s) << 30) | (32'(code) << 28) | (32'(code != 2) << 27));
            wr_tsr(32'hFFFF_FFFF);
            pulse_bit(wdt_bit((s + 1) % 4) > 29 ? 9 : wdt_bit((s + 1) % 4));
            check("R8 other tap ignored", {30'd0, stat_q[31:30]}, 0);
            pulse_bit(wdt_bit(s));
            check("R8 first expiry", {30'd0, stat_q[31:30]}, 2);
            check("R9 no irq yet", {31'd0, wdt_irq}, 0);
            pulse_bit(wdt_bit(s));
            check("R9 second expiry", {30'd0, stat_q[31:30]}, 3);
            check("R9 wdt irq", {31'd0, wdt_irq}, 32'(code != 2));
            tb_value = 32'd1 << wdt_bit(s); cyc();
            check("R10 action code", {30'd0, stat_q[29:28]}, 32'(code));
            check("R10 pulse", {29'd0, rst_core_req, rst_chip_req, rst_sys_req},
                  {29'd0, code == 1, code == 2, code == 3});
            tb_value = '0; cyc();
            check("R10 pulse ends", {29'd0, rst_core_req, rst_chip_req, rst_sys_req}, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule